// File: doc/BRIEF.md
# Path Remote Defect Code Encoder

This block chooses the three-bit remote defect code that the transmit side places in bits 5 to 7 of the outgoing path status overhead byte. It takes six locally detected path defect flags and sorts them into three groups: server (alarm indication or loss of pointer), connectivity (trace identifier mismatch or unequipped), and payload (payload label mismatch or loss of cell delineation). The code of the highest-ranked active group is sent. When no defect is present, the block sends the code for a healthy path.

A single code can travel per frame, so a fixed ranking resolves defects that are present at the same time. The code register loads only on the cycle in which the frame strobe is high. This means the value offered to the overhead inserter never changes part-way through a frame. A defect that is present at a frame strobe shows on the following frame, which is well inside the 100 ms reaction limit. A configuration input can turn off the connectivity group for devices that do not detect those defects.

Top module: `erdi_encoder`

## Requirements
- R1: While reset is asserted and after it is released, before any frame strobe, `erdiCode` is 3'b001.
- R2: If `aisDefect` or `lopDefect` is high in a cycle with `frameStrobe` high, `erdiCode` is 3'b101 from the next cycle on.
- R3: If `connEnable` is high, `timDefect` or `uneqDefect` is high, and no server defect is present at a strobe, `erdiCode` becomes 3'b110 in the next cycle.
- R4: If `plmDefect` or `lcdDefect` is high at a strobe, and neither a server defect nor an enabled connectivity defect is present, `erdiCode` becomes 3'b010.
- R5: If no defect counts at a strobe, `erdiCode` becomes 3'b001.
- R6: Ranking: server outranks connectivity, and connectivity outranks payload, whenever several groups are active at the same strobe.
- R7: If `connEnable` is low at a strobe, `timDefect` and `uneqDefect` have no effect. The code is whatever the other flags select, and it is never 3'b110.
- R8: `erdiCode` changes only in the cycle after a strobe. When `frameStrobe` is low, it holds its value whatever the defect inputs do.
- R9: `erdiCode` is always one of 3'b001, 3'b010, 3'b101 or 3'b110. The values 000, 011, 100 and 111 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| connEnable | input | 1 | High allows the connectivity group to be reported |
| aisDefect | input | 1 | Path alarm indication defect |
| lopDefect | input | 1 | Loss of pointer defect |
| timDefect | input | 1 | Path trace identifier mismatch defect |
| uneqDefect | input | 1 | Path unequipped defect |
| plmDefect | input | 1 | Payload label mismatch defect |
| lcdDefect | input | 1 | Loss of cell delineation defect |
| erdiCode | output | 3 | Code for bits 5 to 7 of the next status byte |

## Verification
Two things can fall in the same cycle: priority resolution between groups and the frame-aligned load. Several groups can become active on the very cycle of a strobe, and a defect can change on the cycle just before a strobe. The bench provokes both cases with random defect vectors that change every cycle while strobes arrive at random. It also uses directed cases in which all groups rise on the strobe cycle, with the connectivity enable both on and off. A reference model built only from the requirements updates its expected code only at strobe edges. It compares this code with the output one cycle after every edge, so any leak from mid-frame inputs or any misranking is caught.

// File: rtl/erdi_pkg.sv
package erdi_pkg;
  localparam int NUM_DEFECTS = 6;
  localparam int NUM_GROUPS  = 3;
  localparam int CODE_W      = 3;

  // group index order is the ranking order (0 highest)
  localparam int GRP_SERVER  = 0;
  localparam int GRP_CONN    = 1;
  localparam int GRP_PAYLOAD = 2;

  // defect vector layout: 0 ais, 1 lop, 2 tim, 3 uneq, 4 plm, 5 lcd
  localparam logic [NUM_DEFECTS-1:0] GROUP_MASK [NUM_GROUPS] = '{
    6'b000011,
    6'b001100,
    6'b110000
  };

  localparam logic [CODE_W-1:0] CODE_SERVER  = 3'b101;
  localparam logic [CODE_W-1:0] CODE_CONN    = 3'b110;
  localparam logic [CODE_W-1:0] CODE_PAYLOAD = 3'b010;
  localparam logic [CODE_W-1:0] CODE_CLEAR   = 3'b001;

  typedef struct packed {
    logic load;       // take a new code at this edge
    logic connAllow;  // connectivity group may be reported
  } erdiStrobes_t;
endpackage

// File: rtl/erdi_ctrl.sv
module erdi_ctrl
  import erdi_pkg::*;
(
  input  logic         frameStrobe,
  input  logic         connEnable,
  output erdiStrobes_t strobes
);
  always_comb begin
    strobes.load      = frameStrobe;
    strobes.connAllow = connEnable;
  end
endmodule

// File: rtl/erdi_datapath.sv
module erdi_datapath
  import erdi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  erdiStrobes_t           strobes,
  input  logic [NUM_DEFECTS-1:0] defects,
  output logic [CODE_W-1:0]      code
);
  logic [NUM_GROUPS-1:0] groupHit;
  logic [CODE_W-1:0]     nextCode;
  logic [CODE_W-1:0]     codeQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign groupHit[g] = |(defects & GROUP_MASK[g]);
  end

  always_comb begin
    if (groupHit[GRP_SERVER])
      nextCode = CODE_SERVER;
    else if (groupHit[GRP_CONN] && strobes.connAllow)
      nextCode = CODE_CONN;
    else if (groupHit[GRP_PAYLOAD])
      nextCode = CODE_PAYLOAD;
    else
      nextCode = CODE_CLEAR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      codeQ <= CODE_CLEAR;
    else if (strobes.load)
      codeQ <= nextCode;
  end

  assign code = codeQ;
endmodule

// File: rtl/erdi_encoder.sv
module erdi_encoder
  import erdi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic              connEnable,
  input  logic              aisDefect,
  input  logic              lopDefect,
  input  logic              timDefect,
  input  logic              uneqDefect,
  input  logic              plmDefect,
  input  logic              lcdDefect,
  output logic [CODE_W-1:0] erdiCode
);
  erdiStrobes_t           strobes;
  logic [NUM_DEFECTS-1:0] defects;

  assign defects = {lcdDefect, plmDefect, uneqDefect, timDefect, lopDefect, aisDefect};

  erdi_ctrl uCtrl (
    .frameStrobe(frameStrobe),
    .connEnable (connEnable),
    .strobes    (strobes)
  );

  erdi_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .defects(defects),
    .code   (erdiCode)
  );
endmodule

// File: rtl/erdi_encoder_checker.sv
module erdi_encoder_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameStrobe,
  input logic       connEnable,
  input logic       aisDefect,
  input logic       lopDefect,
  input logic       timDefect,
  input logic       uneqDefect,
  input logic       plmDefect,
  input logic       lcdDefect,
  input logic [2:0] erdiCode
);
  a_r1_reset_code: assert property (@(posedge clk) !rstN |=> (!rstN -> erdiCode == 3'b001));

  a_r2_server: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && (aisDefect || lopDefect) |=> erdiCode == 3'b101);

  a_r3_conn: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && connEnable && (timDefect || uneqDefect) && !aisDefect && !lopDefect
    |=> erdiCode == 3'b110);

  a_r4_payload: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && (plmDefect || lcdDefect) && !aisDefect && !lopDefect
    && !(connEnable && (timDefect || uneqDefect)) |=> erdiCode == 3'b010);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !aisDefect && !lopDefect && !plmDefect && !lcdDefect
    && !(connEnable && (timDefect || uneqDefect)) |=> erdiCode == 3'b001);

  a_r7_conn_off: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe && !connEnable |=> erdiCode != 3'b110);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(erdiCode));

  a_r9_legal: assert property (@(posedge clk) disable iff (!rstN)
    erdiCode == 3'b001 || erdiCode == 3'b010 || erdiCode == 3'b101 || erdiCode == 3'b110);
endmodule

bind erdi_encoder erdi_encoder_checker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .frameStrobe(frameStrobe),
  .connEnable (connEnable),
  .aisDefect  (aisDefect),
  .lopDefect  (lopDefect),
  .timDefect  (timDefect),
  .uneqDefect (uneqDefect),
  .plmDefect  (plmDefect),
  .lcdDefect  (lcdDefect),
  .erdiCode   (erdiCode)
);

// File: tb/erdi_encoder_test.sv
`timescale 1ns/1ps
module erdi_encoder_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStrobe = 1'b0;
  logic       connEnable = 1'b1;
  logic [5:0] dv = '0; // {lcd, plm, uneq, tim, lop, ais}
  logic [2:0] erdiCode;

  int testsRun = 0;
  int testsFailed = 0;
  logic [2:0] expCode = 3'b001;
  bit done = 1'b0;

  always #5 clk = ~clk;

  erdi_encoder uut (
    .clk        (clk),
    .rstN       (rstN),
    .frameStrobe(frameStrobe),
    .connEnable (connEnable),
    .aisDefect  (dv[0]),
    .lopDefect  (dv[1]),
    .timDefect  (dv[2]),
    .uneqDefect (dv[3]),
    .plmDefect  (dv[4]),
    .lcdDefect  (dv[5]),
    .erdiCode   (erdiCode)
  );

  function automatic logic [2:0] refCode(input logic [5:0] d, input logic en);
    if (d[0] || d[1])               return 3'b101;
    else if (en && (d[2] || d[3]))  return 3'b110;
    else if (d[4] || d[5])          return 3'b010;
    else                            return 3'b001;
  endfunction

  function automatic bit legalCode(input logic [2:0] c);
    return c == 3'b001 || c == 3'b010 || c == 3'b101 || c == 3'b110;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: erdiCode=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, sample 1 ns after it
  task automatic step(input logic strobe, input logic [5:0] d, input logic en, input string req);
    @(negedge clk);
    frameStrobe = strobe;
    dv = d;
    connEnable = en;
    if (strobe) expCode = refCode(d, en);
    @(posedge clk);
    #1;
    check(req, erdiCode, expCode);
    if (!legalCode(erdiCode)) check("R9", erdiCode, expCode ^ 3'b111);
  endtask

  initial begin
    #200000;
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: erdiCode=%b expected=done", erdiCode);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R1: reset value, also with defects present
    dv = 6'b111111;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", erdiCode, 3'b001);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 6'b000001, 1'b1, "R1 after release");

    // directed groups
    step(1'b1, 6'b000001, 1'b1, "R2 ais");
    step(1'b1, 6'b000010, 1'b1, "R2 lop");
    step(1'b1, 6'b000100, 1'b1, "R3 tim");
    step(1'b1, 6'b001000, 1'b1, "R3 uneq");
    step(1'b1, 6'b010000, 1'b1, "R4 plm");
    step(1'b1, 6'b100000, 1'b1, "R4 lcd");
    step(1'b1, 6'b000000, 1'b1, "R5 clear");
    // ranking, all groups raised together on the strobe cycle
    step(1'b1, 6'b111111, 1'b1, "R6 all");
    step(1'b1, 6'b111100, 1'b1, "R6 conn over payload");
    step(1'b1, 6'b110001, 1'b1, "R6 server over payload");
    // connectivity disabled
    step(1'b1, 6'b001100, 1'b0, "R7 conn off alone");
    check("R7 no conn code", erdiCode, 3'b001);
    step(1'b1, 6'b011100, 1'b0, "R7 conn off with payload");
    check("R7 payload shown", erdiCode, 3'b010);
    // hold between strobes
    step(1'b1, 6'b000000, 1'b1, "R5 clear again");
    step(1'b0, 6'b000011, 1'b1, "R8 hold server mid-frame");
    step(1'b0, 6'b010100, 1'b1, "R8 hold other mid-frame");
    check("R8 unchanged", erdiCode, 3'b001);
    step(1'b1, 6'b000100, 1'b1, "R3 after hold");

    // random mix with a fixed seed
    void'($urandom(32'd5417));
    for (int i = 0; i < 3000; i++) begin
      logic s;
      logic [5:0] d;
      logic e;
      s = ($urandom % 4) == 0;
      d = 6'($urandom);
      if (($urandom % 3) == 0) d = '0;
      e = ($urandom % 4) != 0;
      step(s, d, e, s ? "R6 random strobe" : "R8 random hold");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule